// File: doc/BRIEF.md
# Synchronous Rectification Gate Controller

This block drives the four switch enables of one H-bridge: a high and a low switch on each of two legs, A and B. Each cycle it takes the chopper's current phase, the bridge direction and a 2-bit rectification policy. It then decides which switches conduct while the bridge drives, and which conduct while the load current recirculates. The policy sets three things: the switch pair that is chopped when the off time begins, whether the idle switches are turned on to bypass their body diodes, and what ends that rectification early.

Two flags from the analog current sense can end rectification before the off time is over. The first reports that the load current has reached zero. The second reports that reversed current has reached the limit. Once either flag has turned rectification off, it stays off until the next drive phase. Every switch change is registered. Before a switch turns on, the other switch of the same leg must have been off for at least `DEAD_CYC` cycles. Sleep or a fault forces all four enables low in the same cycle and also clears the registered state.

Top module: `srgc_gate_ctrl`

## Requirements
- R1: With phase code 1 (drive) and direction 1, the steady enables are leg-A high and leg-B low, written as 1001 in the order {A high, A low, B high, B low}. With direction 0 they are leg-B high and leg-A low (0110). Leg A is the source leg when direction is 1, and leg B is the source leg when direction is 0. The other leg is the sink leg.
- R2: Phase code 0 (bridge idle) turns every enable off one clock edge after it is applied.
- R3: In phase code 2 (fast decay), with policy 0 (active) or policy 1 (passive) and rectification not ended, the enables are the sink-leg high switch and the source-leg low switch.
- R4: In phase code 3 (slow decay), with any policy other than 3, the source-leg high switch is chopped. The sink-leg low switch stays on, and the source-leg low switch is on while rectification is allowed.
- R5: Policy 3 (low side only) never turns on a high switch for rectification. In slow decay the sink-leg low switch is chopped and only the source-leg high switch stays on. In fast decay only the source-leg low switch is on.
- R6: Policy 2 (no rectification) turns no switch on in fast decay. In slow decay it turns on only the sink-leg low switch.
- R7: Under policy 0, the zero-current flag raised during decay turns the rectifying switches off one edge later. They stay off after the flag drops and come back only after a drive phase.
- R8: Under policy 1, the zero-current flag has no effect. The reverse-limit flag raised during decay turns the rectifying switches off one edge later, and they stay off after the flag drops.
- R9: The two switches of a leg are never on together. A switch turns on only after the other switch of its leg has been off for at least `DEAD_CYC` cycles (default 2).
- R10: Sleep or fault forces all four enables low in the same cycle. The cleared state then lets the enables return one edge after the force is released.
- R11: After reset all four enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | 2 | 0 idle, 1 drive, 2 fast decay, 3 slow decay |
| dir_i | input | 1 | 1: leg A sources; 0: leg B sources |
| mode_i | input | 2 | 0 active, 1 passive, 2 none, 3 low side only |
| zero_det_i | input | 1 | Load current reached zero |
| rev_lim_i | input | 1 | Reversed current reached the limit |
| sleep_i | input | 1 | Forces all enables low |
| fault_i | input | 1 | Forces all enables low |
| gate_ah_o | output | 1 | Leg A high switch enable |
| gate_al_o | output | 1 | Leg A low switch enable |
| gate_bh_o | output | 1 | Leg B high switch enable |
| gate_bl_o | output | 1 | Leg B low switch enable |

## Verification
The hardest case to reach is the latched end of rectification. The flag must arrive while decay is under way, under the policy that honours it. The bench must then show that lowering the flag, and even moving on to the other decay phase, brings nothing back. The stimulus first builds up each decay state with its switches settled. It then raises the flag for one policy and checks that the other flag is ignored. After that it holds the decay phase with the flag low, and only then issues a drive phase followed by a fresh decay. Every crossing from one diagonal to the other is sampled on each edge, to pin down the exact dead-time window.

// File: rtl/srgc_pkg.sv
package srgc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DRIVE = 2'd1,
      PH_FAST  = 2'd2,
      PH_SLOW  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      RM_ACTIVE  = 2'd0,
      RM_PASSIVE = 2'd1,
      RM_NONE    = 2'd2,
      RM_LOWONLY = 2'd3
   } rect_mode_e;

   typedef struct packed {
      logic hi;
      logic lo;
   } leg_t;
endpackage

// File: rtl/srgc_policy.sv
module srgc_policy
   import srgc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  phase_e     phase,
   input  logic       dir,
   input  rect_mode_e mode,
   input  logic       zero_det,
   input  logic       rev_lim,
   input  logic       force_off,
   output leg_t       tgt_a,
   output leg_t       tgt_b
);
   logic kill_q;
   logic kill_evt;
   logic in_decay;
   logic rect_ok;
   leg_t src;
   leg_t snk;

   assign in_decay = (phase == PH_FAST) || (phase == PH_SLOW);
   assign kill_evt = in_decay &&
                     (((mode == RM_ACTIVE)  && zero_det) ||
                      ((mode == RM_PASSIVE) && rev_lim));
   assign rect_ok  = ((mode == RM_ACTIVE) || (mode == RM_PASSIVE)) &&
                     !kill_q && !kill_evt;

   always_ff @(posedge clk) begin
      if (!rst_n || force_off || phase == PH_DRIVE) begin
         kill_q <= 1'b0;
      end else if (kill_evt) begin
         kill_q <= 1'b1;
      end
   end

   always_comb begin
      src = '0;
      snk = '0;
      unique case (phase)
         PH_DRIVE: begin
            src.hi = 1'b1;
            snk.lo = 1'b1;
         end
         PH_FAST: begin
            if (mode == RM_LOWONLY) begin
               src.lo = 1'b1;
            end else if (rect_ok) begin
               snk.hi = 1'b1;
               src.lo = 1'b1;
            end
         end
         PH_SLOW: begin
            if (mode == RM_LOWONLY) begin
               src.hi = 1'b1;
            end else begin
               snk.lo = 1'b1;
               src.lo = rect_ok;
            end
         end
         default: begin
            src = '0;
            snk = '0;
         end
      endcase
   end

   assign tgt_a = dir ? src : snk;
   assign tgt_b = dir ? snk : src;

   AST_KILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_q && phase != PH_DRIVE && !force_off) |=> kill_q); // R7
endmodule

// File: rtl/srgc_leg.sv
module srgc_leg
   import srgc_pkg::*;
#(
   parameter int DEAD_CYC = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic force_off,
   input  leg_t tgt,
   output leg_t gate
);
   localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
   localparam logic [CW-1:0] CMAX = CW'(DEAD_CYC);

   logic          hi_q, lo_q;
   logic          hi_g, lo_g;
   logic          hi_d, lo_d;
   logic          may_hi, may_lo;
   logic [CW-1:0] hi_off_q, lo_off_q;
   logic [CW-1:0] hi_off_d, lo_off_d;

   assign hi_g = hi_q & ~force_off;
   assign lo_g = lo_q & ~force_off;

   assign hi_off_d = hi_g ? '0 : ((hi_off_q == CMAX) ? CMAX : hi_off_q + CW'(1));
   assign lo_off_d = lo_g ? '0 : ((lo_off_q == CMAX) ? CMAX : lo_off_q + CW'(1));

   assign may_lo = ~hi_g && (hi_off_d == CMAX);
   assign may_hi = ~lo_g && (lo_off_d == CMAX);

   assign hi_d = ~force_off & tgt.hi & ~tgt.lo & (hi_q | may_hi);
   assign lo_d = ~force_off & tgt.lo & ~tgt.hi & (lo_q | may_lo);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q     <= 1'b0;
         lo_q     <= 1'b0;
         hi_off_q <= CMAX;
         lo_off_q <= CMAX;
      end else begin
         hi_q     <= hi_d;
         lo_q     <= lo_d;
         hi_off_q <= hi_off_d;
         lo_off_q <= lo_off_d;
      end
   end

   assign gate.hi = hi_g;
   assign gate.lo = lo_g;

   AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_g && lo_g)); // R9
   AST_DEAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_g) |-> $past(!lo_g)); // R9
   AST_DEAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_g) |-> $past(!hi_g)); // R9
   AST_FORCE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> (!hi_q && !lo_q)); // R10
endmodule

// File: rtl/srgc_gate_ctrl.sv
module srgc_gate_ctrl
   import srgc_pkg::*;
#(
   parameter int DEAD_CYC = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] phase_i,
   input  logic       dir_i,
   input  logic [1:0] mode_i,
   input  logic       zero_det_i,
   input  logic       rev_lim_i,
   input  logic       sleep_i,
   input  logic       fault_i,
   output logic       gate_ah_o,
   output logic       gate_al_o,
   output logic       gate_bh_o,
   output logic       gate_bl_o
);
   localparam int N_LEGS = 2;

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("srgc_gate_ctrl: DEAD_CYC must be at least 1");
   end

   logic force_off;
   leg_t tgt_a, tgt_b;
   leg_t tgt_arr [N_LEGS];
   leg_t gate_arr [N_LEGS];

   assign force_off = sleep_i | fault_i;

   srgc_policy i_policy (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase_e'(phase_i)),
      .dir       (dir_i),
      .mode      (rect_mode_e'(mode_i)),
      .zero_det  (zero_det_i),
      .rev_lim   (rev_lim_i),
      .force_off (force_off),
      .tgt_a     (tgt_a),
      .tgt_b     (tgt_b)
   );

   assign tgt_arr[0] = tgt_a;
   assign tgt_arr[1] = tgt_b;

   for (genvar gi = 0; gi < N_LEGS; gi++) begin : g_leg
      srgc_leg #(.DEAD_CYC(DEAD_CYC)) i_leg (
         .clk       (clk),
         .rst_n     (rst_n),
         .force_off (force_off),
         .tgt       (tgt_arr[gi]),
         .gate      (gate_arr[gi])
      );
   end

   assign gate_ah_o = gate_arr[0].hi;
   assign gate_al_o = gate_arr[0].lo;
   assign gate_bh_o = gate_arr[1].hi;
   assign gate_bl_o = gate_arr[1].lo;

   AST_LSO_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd3 && $past(mode_i) == 2'd3 &&
       phase_i == 2'd2 && $past(phase_i) == 2'd2)
      |-> (!gate_ah_o && !gate_bh_o)); // R5
   AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i || fault_i) |=> ($past(sleep_i || fault_i) && (sleep_i || fault_i))
      |-> !(gate_ah_o || gate_al_o || gate_bh_o || gate_bl_o)); // R10
endmodule

// File: tb/test_srgc_gate_ctrl.sv
module test_srgc_gate_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] phase_i = 2'd0;
   logic       dir_i = 1'b1;
   logic [1:0] mode_i = 2'd0;
   logic       zero_det_i = 1'b0;
   logic       rev_lim_i = 1'b0;
   logic       sleep_i = 1'b0;
   logic       fault_i = 1'b0;
   logic       gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0] exp;
      string      tag;
   } item_t;

   item_t sb_q[$];
   event  sb_ev;

   always #2 clk = ~clk;

   srgc_gate_ctrl #(.DEAD_CYC(2)) i_srgc_gate_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase_i    (phase_i),
      .dir_i      (dir_i),
      .mode_i     (mode_i),
      .zero_det_i (zero_det_i),
      .rev_lim_i  (rev_lim_i),
      .sleep_i    (sleep_i),
      .fault_i    (fault_i),
      .gate_ah_o  (gate_ah_o),
      .gate_al_o  (gate_al_o),
      .gate_bh_o  (gate_bh_o),
      .gate_bl_o  (gate_bl_o)
   );

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         @(sb_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [3:0] got;
            it  = sb_q.pop_front();
            got = {gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o};
            checks++;
            if (got !== it.exp) begin
               errors++;
               $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
            end
         end
      end
   end

   task automatic drv(input logic [1:0] ph, input logic dr, input logic [1:0] md,
                      input logic zd, input logic rl, input logic sl, input logic ft);
      @(negedge clk);
      phase_i = ph; dir_i = dr; mode_i = md;
      zero_det_i = zd; rev_lim_i = rl; sleep_i = sl; fault_i = ft;
   endtask

   task automatic chk(input int n, input logic [3:0] exp, input string tag);
      item_t it;
      if (n == 0) #1;
      else begin
         repeat (n) @(posedge clk);
         #1;
      end
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      ->sb_ev;
      #0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(0, 4'b0000, "R11 outputs low in reset");
      @(negedge clk);
      rst_n = 1'b1;
      chk(1, 4'b0000, "R11 outputs low after reset");

      // drive both directions, dead time on reversal
      drv(2'd1, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(1, 4'b1001, "R1 drive dir1");
      chk(2, 4'b1001, "R1 drive dir1 steady");
      drv(2'd1, 1'b0, 2'd0, 0, 0, 0, 0);
      chk(1, 4'b0000, "R9 reversal edge1 all off");
      chk(1, 4'b0000, "R9 reversal edge2 still off");
      chk(1, 4'b0110, "R1 drive dir0 after dead time");
      drv(2'd1, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(4, 4'b1001, "R1 drive dir1 again");

      // active policy: fast then slow decay
      drv(2'd2, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(1, 4'b0000, "R9 fast entry dead time");
      chk(2, 4'b0110, "R3 fast decay rectifies");
      drv(2'd3, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(1, 4'b0100, "R4 slow decay edge1");
      chk(2, 4'b0101, "R4 slow decay both lows");

      // active kill by zero current
      drv(2'd3, 1'b1, 2'd0, 1, 0, 0, 0);
      chk(1, 4'b0001, "R7 zero detect ends rectification");
      drv(2'd3, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(3, 4'b0001, "R7 stays off after flag drops");
      drv(2'd2, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(2, 4'b0000, "R7 fast decay still killed");
      drv(2'd1, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(1, 4'b1001, "R1 drive after kill");
      drv(2'd2, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(3, 4'b0110, "R7 rectification back after drive");

      // passive policy
      drv(2'd1, 1'b1, 2'd1, 0, 0, 0, 0);
      chk(4, 4'b1001, "R1 drive passive");
      drv(2'd2, 1'b1, 2'd1, 1, 0, 0, 0);
      chk(3, 4'b0110, "R8 zero detect ignored in passive");
      drv(2'd2, 1'b1, 2'd1, 1, 1, 0, 0);
      chk(1, 4'b0000, "R8 reverse limit ends rectification");
      drv(2'd2, 1'b1, 2'd1, 0, 0, 0, 0);
      chk(2, 4'b0000, "R8 stays off after flag drops");

      // no rectification
      drv(2'd1, 1'b0, 2'd2, 0, 0, 0, 0);
      chk(3, 4'b0110, "R1 drive dir0 policy none");
      drv(2'd2, 1'b0, 2'd2, 0, 0, 0, 0);
      chk(1, 4'b0000, "R6 fast decay no switch");
      drv(2'd3, 1'b0, 2'd2, 0, 0, 0, 0);
      chk(2, 4'b0100, "R6 slow decay sink low only");

      // low side only
      drv(2'd1, 1'b1, 2'd3, 0, 0, 0, 0);
      chk(4, 4'b1001, "R1 drive low-side-only");
      drv(2'd3, 1'b1, 2'd3, 0, 0, 0, 0);
      chk(1, 4'b1000, "R5 slow decay chops sink");
      drv(2'd2, 1'b1, 2'd3, 0, 0, 0, 0);
      chk(1, 4'b0000, "R5 fast entry dead time");
      chk(2, 4'b0100, "R5 fast decay source low only");

      // idle
      drv(2'd0, 1'b1, 2'd3, 0, 0, 0, 0);
      chk(1, 4'b0000, "R2 idle all off");

      // sleep and fault
      drv(2'd1, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(4, 4'b1001, "R1 drive before sleep");
      drv(2'd1, 1'b1, 2'd0, 0, 0, 1, 0);
      chk(0, 4'b0000, "R10 sleep forces low at once");
      chk(1, 4'b0000, "R10 sleep holds low");
      drv(2'd1, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(1, 4'b1001, "R10 resume after sleep");
      drv(2'd1, 1'b1, 2'd0, 0, 0, 0, 1);
      chk(0, 4'b0000, "R10 fault forces low at once");
      drv(2'd1, 1'b1, 2'd0, 0, 0, 0, 0);
      chk(1, 4'b1001, "R10 resume after fault");

      repeat (2) @(posedge clk);
      #1;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule